// File: doc/BRIEF.md
# Hit-Under-Miss Data Cache Controller

This block is the control and storage core of a small lockup-free data cache. The cache is eight-way set associative with 64-byte lines. A CPU load port accepts one request per cycle under a valid/ready handshake. Each request carries an identifier, and every response returns that identifier with the loaded word. When a load misses, the block sends one line request to the next level, which returns the whole line a fixed 10 cycles later. While that miss is outstanding, loads that hit are still accepted and answered. Their responses can therefore overtake the pending miss.

Only one miss may be outstanding at a time. A later load to the same line as the pending miss is attached to the miss register and answered once the line has arrived. A load that misses on any other line holds ready low until the pending miss has been fully answered. The block also counts the cycles in which the CPU port is actually stalled. This count differs from the number of cycles a miss is in flight, because hits keep flowing during a miss.

Top module: `nb_dcache_ctrl`

## Requirements
- R1: After reset, `req_ready_o` is high, `rsp_valid_o` and `fill_req_valid_o` are low, `stall_cnt_o` is zero, and every line is invalid, so the first load to any address misses.
- R2: A load that hits is answered in the cycle after acceptance with `rsp_id_o` equal to its identifier. `rsp_data_o` is the 32-bit word selected by address bits [5:2] of that line.
- R3: A load that misses while no miss is pending is accepted. In the next cycle `fill_req_valid_o` is high for exactly one cycle, and `fill_req_addr_o` holds the load address with bits [5:0] cleared.
- R4: While a miss is pending, loads that hit are accepted and answered as in R2, ahead of the pending miss's response.
- R5: While a miss is pending, a load to the same line is accepted and merged, up to two loads in total per miss. A further load to that line holds ready low.
- R6: While a miss is pending, a load that misses on another line sees ready low until the pending miss has returned all of its responses. The load is then handled as in R3.
- R7: In a cycle where `fill_valid_i` is high and a miss is pending, ready is low and the line is installed. In `fill_data_i`, word k lies in bits [32k+31:32k]. From the next cycle on, the loads of that miss are answered one per cycle in acceptance order, and ready stays low until the last of them.
- R8: The four sets are selected by address bits [7:6]. Each set fills its ways in round-robin order starting at way 0. A ninth distinct line in a set evicts the first line filled there.
- R9: `stall_cnt_o` increases by one in the cycle after each cycle in which `req_valid_i` is high and `req_ready_o` is low. It does not change otherwise.
- R10: `fill_valid_i` is ignored while no miss is pending. No line is installed, so a later load to that line still misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request valid |
| req_ready_o | output | 1 | Load request accepted this cycle when high with valid |
| req_addr_i | input | 32 | Load byte address |
| req_id_i | input | 4 | Load identifier |
| rsp_valid_o | output | 1 | Response valid |
| rsp_id_o | output | 4 | Identifier of the answered load |
| rsp_data_o | output | 32 | Loaded word |
| fill_req_valid_o | output | 1 | Line request to the next level (one-cycle pulse) |
| fill_req_addr_o | output | 32 | Line-aligned address of the request |
| fill_valid_i | input | 1 | Line returned by the next level |
| fill_data_i | input | 512 | Returned line, word k in bits [32k+31:32k] |
| stall_cnt_o | output | 32 | Count of stalled request cycles |

## Verification
A wrong tag, valid bit or round-robin pointer shows up as a hit/miss decision that differs from the reference. That difference appears in the same cycle on `req_ready_o`, or one cycle later as an unexpected `fill_req_valid_o` or a missing response. A corrupted miss register surfaces after the refill, up to 11 cycles after the miss: merged responses come back with the wrong identifier, word, order or count. A faulty stall condition moves `stall_cnt_o` away from the reference one cycle after the cycle it miscounts.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRAIN = 2'd2
  } nbc_state_e;
endpackage

// File: rtl/nbc_array.sv
module nbc_array #(
  parameter int BLK_W  = 26,
  parameter int WSEL_W = 4,
  parameter int WORD_W = 32,
  parameter int WAYS   = 8,
  parameter int SETS   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [BLK_W-1:0]          lk_blk_i,
  input  logic [WSEL_W-1:0]         lk_wsel_i,
  output logic                      hit_o,
  output logic [WORD_W-1:0]         word_o,
  input  logic                      fill_en_i,
  input  logic [BLK_W-1:0]          fill_blk_i,
  input  logic [WORD_W*(1<<WSEL_W)-1:0] fill_line_i
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = BLK_W - IDX_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int LINE_W = WORD_W * (1 << WSEL_W);

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [LINE_W-1:0] data_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAY_W-1:0]  rr_q   [SETS];

  logic [IDX_W-1:0] lk_idx, fi_idx;
  logic [TAG_W-1:0] lk_tag, fi_tag;
  logic [WAYS-1:0]  match;

  assign lk_idx = lk_blk_i[IDX_W-1:0];
  assign lk_tag = lk_blk_i[BLK_W-1:IDX_W];
  assign fi_idx = fill_blk_i[IDX_W-1:0];
  assign fi_tag = fill_blk_i[BLK_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  assign hit_o = |match;

  always_comb begin
    word_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) word_o = data_q[lk_idx][w][lk_wsel_i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (fill_en_i) begin
      vld_q[fi_idx][rr_q[fi_idx]] <= 1'b1;
      rr_q[fi_idx]                <= rr_q[fi_idx] + 1'b1;
    end
  end

  // Tag and data storage carry no reset; valid bits gate them.
  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      tag_q[fi_idx][rr_q[fi_idx]]  <= fi_tag;
      data_q[fi_idx][rr_q[fi_idx]] <= fill_line_i;
    end
  end
endmodule

// File: rtl/nbc_mshr.sv
module nbc_mshr #(
  parameter int BLK_W  = 26,
  parameter int WSEL_W = 4,
  parameter int ID_W   = 4,
  parameter int TGT    = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_i,
  input  logic                       merge_i,
  input  logic [BLK_W-1:0]           blk_i,
  input  logic [ID_W-1:0]            id_i,
  input  logic [WSEL_W-1:0]          wsel_i,
  input  logic [$clog2(TGT)-1:0]     sel_i,
  output logic [BLK_W-1:0]           blk_o,
  output logic [$clog2(TGT+1)-1:0]   cnt_o,
  output logic                       full_o,
  output logic [ID_W-1:0]            sel_id_o,
  output logic [WSEL_W-1:0]          sel_wsel_o
);
  localparam int CW = $clog2(TGT + 1);

  logic [BLK_W-1:0]  blk_q;
  logic [CW-1:0]     cnt_q;
  logic [ID_W-1:0]   id_q [TGT];
  logic [WSEL_W-1:0] ws_q [TGT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= '0;
      cnt_q <= '0;
    end else if (alloc_i) begin
      blk_q <= blk_i;
      cnt_q <= CW'(1);
    end else if (merge_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int t = 0; t < TGT; t++) begin
      if ((alloc_i && t == 0) || (merge_i && !alloc_i && int'(cnt_q) == t)) begin
        id_q[t] <= id_i;
        ws_q[t] <= wsel_i;
      end
    end
  end

  assign blk_o      = blk_q;
  assign cnt_o      = cnt_q;
  assign full_o     = (cnt_q == CW'(TGT));
  assign sel_id_o   = id_q[sel_i];
  assign sel_wsel_o = ws_q[sel_i];
endmodule

// File: rtl/nb_dcache_ctrl.sv
module nb_dcache_ctrl
  import nbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int WORD_W = 32,
  parameter int WAYS   = 8,
  parameter int SETS   = 4,
  parameter int LINE_B = 64,
  parameter int TGT    = 2,
  parameter int CNT_W  = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [ID_W-1:0]        req_id_i,
  output logic                   rsp_valid_o,
  output logic [ID_W-1:0]        rsp_id_o,
  output logic [WORD_W-1:0]      rsp_data_o,
  output logic                   fill_req_valid_o,
  output logic [ADDR_W-1:0]      fill_req_addr_o,
  input  logic                   fill_valid_i,
  input  logic [LINE_B*8-1:0]    fill_data_i,
  output logic [CNT_W-1:0]       stall_cnt_o
);
  localparam int OFF_W  = $clog2(LINE_B);
  localparam int BOFF_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BOFF_W;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int PTR_W  = $clog2(TGT);
  localparam int CW     = $clog2(TGT + 1);

  nbc_state_e state_q, state_d;
  logic [PTR_W-1:0] ptr_q;

  logic [BLK_W-1:0]  req_blk, lk_blk, m_blk;
  logic [WSEL_W-1:0] req_wsel, lk_wsel, sel_wsel;
  logic [ID_W-1:0]   sel_id;
  logic [CW-1:0]     m_cnt;
  logic              m_full, hit;
  logic [WORD_W-1:0] hit_word;
  logic              ready, do_hit, do_alloc, do_merge, do_fill, do_drain, last_tgt;
  logic              unused_boff;

  assign req_blk     = req_addr_i[ADDR_W-1:OFF_W];
  assign req_wsel    = req_addr_i[OFF_W-1:BOFF_W];
  assign unused_boff = ^req_addr_i[BOFF_W-1:0];

  // During drain the lookup port replays the merged loads.
  assign lk_blk   = (state_q == ST_DRAIN) ? m_blk : req_blk;
  assign lk_wsel  = (state_q == ST_DRAIN) ? sel_wsel : req_wsel;
  assign last_tgt = (CW'(ptr_q) + 1'b1) == m_cnt;

  nbc_array #(
    .BLK_W(BLK_W), .WSEL_W(WSEL_W), .WORD_W(WORD_W), .WAYS(WAYS), .SETS(SETS)
  ) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_blk_i    (lk_blk),
    .lk_wsel_i   (lk_wsel),
    .hit_o       (hit),
    .word_o      (hit_word),
    .fill_en_i   (do_fill),
    .fill_blk_i  (m_blk),
    .fill_line_i (fill_data_i)
  );

  nbc_mshr #(
    .BLK_W(BLK_W), .WSEL_W(WSEL_W), .ID_W(ID_W), .TGT(TGT)
  ) u_mshr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_i    (do_alloc),
    .merge_i    (do_merge),
    .blk_i      (req_blk),
    .id_i       (req_id_i),
    .wsel_i     (req_wsel),
    .sel_i      (ptr_q),
    .blk_o      (m_blk),
    .cnt_o      (m_cnt),
    .full_o     (m_full),
    .sel_id_o   (sel_id),
    .sel_wsel_o (sel_wsel)
  );

  always_comb begin
    ready    = 1'b0;
    do_hit   = 1'b0;
    do_alloc = 1'b0;
    do_merge = 1'b0;
    do_fill  = 1'b0;
    do_drain = 1'b0;
    state_d  = state_q;
    unique case (state_q)
      ST_IDLE: begin
        ready = 1'b1;
        if (req_valid_i) begin
          if (hit) do_hit = 1'b1;
          else begin
            do_alloc = 1'b1;
            state_d  = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (fill_valid_i) begin
          do_fill = 1'b1;
          state_d = ST_DRAIN;
        end else if (hit) begin
          ready  = 1'b1;
          do_hit = req_valid_i;
        end else if (req_blk == m_blk && !m_full) begin
          ready    = 1'b1;
          do_merge = req_valid_i;
        end
      end
      ST_DRAIN: begin
        do_drain = 1'b1;
        if (last_tgt) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign req_ready_o = ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q          <= ST_IDLE;
      ptr_q            <= '0;
      rsp_valid_o      <= 1'b0;
      rsp_id_o         <= '0;
      rsp_data_o       <= '0;
      fill_req_valid_o <= 1'b0;
      fill_req_addr_o  <= '0;
      stall_cnt_o      <= '0;
    end else begin
      state_q          <= state_d;
      rsp_valid_o      <= do_hit | do_drain;
      fill_req_valid_o <= do_alloc;
      if (do_fill) ptr_q <= '0;
      else if (do_drain) ptr_q <= ptr_q + 1'b1;
      if (do_hit | do_drain) begin
        rsp_id_o   <= do_drain ? sel_id : req_id_i;
        rsp_data_o <= hit_word;
      end
      if (do_alloc) fill_req_addr_o <= {req_blk, {OFF_W{1'b0}}};
      if (req_valid_i && !ready) stall_cnt_o <= stall_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/nb_dcache_ctrl_chk.sv
module nb_dcache_ctrl_chk
  import nbc_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int CNT_W = 32,
  parameter int CW    = 2,
  parameter int TGT   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [ID_W-1:0]  req_id_i,
  input logic             rsp_valid_o,
  input logic [ID_W-1:0]  rsp_id_o,
  input logic             fill_req_valid_o,
  input logic             fill_valid_i,
  input logic [CNT_W-1:0] stall_cnt_o,
  input nbc_state_e       state_q,
  input logic             hit,
  input logic [CW-1:0]    m_cnt
);
  // R2: accepted hit is answered next cycle with its own id
  a_r2_hit_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && hit && state_q != ST_DRAIN)
      |=> (rsp_valid_o && rsp_id_o == $past(req_id_i)));

  // R3: line request is a single-cycle pulse
  a_r3_fill_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_valid_o |=> !fill_req_valid_o);

  // R5: miss register never holds more loads than slots
  a_r5_tgt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_cnt <= CW'(TGT));

  // R7: refill cycle and drain block the port
  a_r7_fill_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && fill_valid_i) |-> !req_ready_o);

  a_r7_drain_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN) |-> (!req_ready_o && $past(state_q) != ST_IDLE));

  // R9: stalled cycle bumps the counter
  a_r9_stall_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> (stall_cnt_o == CNT_W'($past(stall_cnt_o) + 1'b1)));

  // R10: stray refill in idle changes nothing
  a_r10_idle_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && fill_valid_i && !req_valid_i) |=> (state_q == ST_IDLE && !rsp_valid_o));
endmodule

bind nb_dcache_ctrl nb_dcache_ctrl_chk #(
  .ID_W(ID_W), .CNT_W(CNT_W), .CW(CW), .TGT(TGT)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_valid_i      (req_valid_i),
  .req_ready_o      (req_ready_o),
  .req_id_i         (req_id_i),
  .rsp_valid_o      (rsp_valid_o),
  .rsp_id_o         (rsp_id_o),
  .fill_req_valid_o (fill_req_valid_o),
  .fill_valid_i     (fill_valid_i),
  .stall_cnt_o      (stall_cnt_o),
  .state_q          (state_q),
  .hit              (hit),
  .m_cnt            (m_cnt)
);

// File: tb/sim_nb_dcache_ctrl.sv
`timescale 1ns/1ps
module sim_nb_dcache_ctrl;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [31:0]  req_addr_i = '0;
  logic [3:0]   req_id_i = '0;
  logic         rsp_valid_o;
  logic [3:0]   rsp_id_o;
  logic [31:0]  rsp_data_o;
  logic         fill_req_valid_o;
  logic [31:0]  fill_req_addr_o;
  logic         fill_valid_i = 1'b0;
  logic [511:0] fill_data_i = '0;
  logic [31:0]  stall_cnt_o;

  always #4 clk = ~clk;

  nb_dcache_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_id_i(req_id_i),
    .rsp_valid_o(rsp_valid_o), .rsp_id_o(rsp_id_o), .rsp_data_o(rsp_data_o),
    .fill_req_valid_o(fill_req_valid_o), .fill_req_addr_o(fill_req_addr_o),
    .fill_valid_i(fill_valid_i), .fill_data_i(fill_data_i),
    .stall_cnt_o(stall_cnt_o)
  );

  int total = 0, bad = 0;
  string phase = "R1";

  // reference model state
  logic [23:0] mtag [4][8];
  bit          mval [4][8];
  int          mrr  [4];
  int          mode = 0;        // 0 idle, 1 waiting, 2 answering
  logic [25:0] mblk = '0;
  int          tq_id[$], tq_w[$];
  int          cd = 0;
  bit          armed = 0, last_acc = 0;
  bit          spur = 0;
  logic [25:0] spur_blk = '0;
  bit          exp_rv = 0, exp_fv = 0;
  logic [3:0]  exp_rid = '0;
  logic [31:0] exp_rdata = '0, exp_faddr = '0, exp_stall = '0;

  function automatic logic [31:0] mem_word(logic [31:0] waddr);
    return (waddr * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [511:0] mk_line(logic [25:0] blk);
    logic [511:0] l;
    for (int k = 0; k < 16; k++) l[k*32 +: 32] = mem_word({2'b00, blk, 4'(k)});
    return l;
  endfunction

  function automatic logic [31:0] ad(int tg, int st, int wd);
    return {24'(tg), 2'(st), 4'(wd), 2'b00};
  endfunction

  function automatic bit mhit(logic [31:0] a);
    for (int w = 0; w < 8; w++)
      if (mval[a[7:6]][w] && mtag[a[7:6]][w] == a[31:8]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit v, logic [31:0] a, logic [3:0] id);
    bit fv_now, rdy;
    @(negedge clk);
    chk(rsp_valid_o == exp_rv, phase, "rsp_valid", 64'(rsp_valid_o), 64'(exp_rv));
    if (exp_rv) begin
      chk(rsp_id_o == exp_rid, phase, "rsp_id", 64'(rsp_id_o), 64'(exp_rid));
      chk(rsp_data_o == exp_rdata, phase, "rsp_data", 64'(rsp_data_o), 64'(exp_rdata));
    end
    chk(fill_req_valid_o == exp_fv, "R3", "fill_req_valid", 64'(fill_req_valid_o), 64'(exp_fv));
    if (exp_fv) chk(fill_req_addr_o == exp_faddr, "R3", "fill_req_addr", 64'(fill_req_addr_o), 64'(exp_faddr));
    chk(stall_cnt_o == exp_stall, "R9", "stall_cnt", 64'(stall_cnt_o), 64'(exp_stall));
    // next-level model: data arrives 10 cycles after the request pulse
    if (armed) cd--;
    fv_now = armed && cd == 0;
    if (fv_now) armed = 0;
    req_valid_i  = v;
    req_addr_i   = a;
    req_id_i     = id;
    fill_valid_i = fv_now || spur;
    fill_data_i  = spur ? mk_line(spur_blk) : mk_line(mblk);
    spur = 0;
    #1;
    case (mode)
      0: rdy = 1'b1;
      1: rdy = fv_now ? 1'b0 : (mhit(a) ? 1'b1 : (a[31:6] == mblk && tq_id.size() < 2));
      default: rdy = 1'b0;
    endcase
    chk(req_ready_o == rdy, phase, "req_ready", 64'(req_ready_o), 64'(rdy));
    // commit the edge
    exp_rv = 0; exp_fv = 0;
    last_acc = v && rdy;
    if (v && !rdy) exp_stall++;
    case (mode)
      0: if (v) begin
        if (mhit(a)) begin
          exp_rv = 1; exp_rid = id; exp_rdata = mem_word({2'b00, a[31:2]});
        end else begin
          mblk = a[31:6]; tq_id = {int'(id)}; tq_w = {int'(a[5:2])};
          mode = 1; armed = 1; cd = 11;
          exp_fv = 1; exp_faddr = {a[31:6], 6'b0};
        end
      end
      1: if (fv_now) begin
        mtag[mblk[1:0]][mrr[mblk[1:0]]] = mblk[25:2];
        mval[mblk[1:0]][mrr[mblk[1:0]]] = 1;
        mrr[mblk[1:0]] = (mrr[mblk[1:0]] + 1) % 8;
        mode = 2;
      end else if (last_acc) begin
        if (mhit(a)) begin
          exp_rv = 1; exp_rid = id; exp_rdata = mem_word({2'b00, a[31:2]});
        end else begin
          tq_id.push_back(int'(id)); tq_w.push_back(int'(a[5:2]));
        end
      end
      default: begin
        exp_rv = 1;
        exp_rid = 4'(tq_id.pop_front());
        exp_rdata = mem_word({2'b00, mblk, 4'(tq_w.pop_front())});
        if (tq_id.size() == 0) mode = 0;
      end
    endcase
  endtask

  task automatic send(logic [31:0] a, logic [3:0] id);
    do cyc(1, a, id); while (!last_acc);
  endtask

  task automatic settle();
    while (mode != 0) cyc(0, '0, '0);
    cyc(0, '0, '0);
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      mrr[s] = 0;
      for (int w = 0; w < 8; w++) begin mval[s][w] = 0; mtag[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    phase = "R1";
    repeat (3) cyc(0, '0, '0);
    // R3: cold miss, then R7 refill and answer
    phase = "R3"; cyc(1, ad(1, 0, 3), 4'd1);
    phase = "R7"; settle();
    // R2: back-to-back hits on the filled line
    phase = "R2";
    cyc(1, ad(1, 0, 0), 4'd2); cyc(1, ad(1, 0, 15), 4'd3); cyc(1, ad(1, 0, 3), 4'd4);
    cyc(0, '0, '0);
    // R4: hits overtake a pending miss
    phase = "R4";
    cyc(1, ad(2, 1, 5), 4'd5);
    cyc(1, ad(1, 0, 7), 4'd6); cyc(0, '0, '0); cyc(1, ad(1, 0, 8), 4'd7);
    // R5: merge one load, then a third to the same line stalls
    phase = "R5";
    cyc(1, ad(2, 1, 9), 4'd8);
    send(ad(2, 1, 1), 4'd9);
    phase = "R7"; settle();
    // R6: miss on another line waits for the pending miss to finish
    phase = "R6";
    cyc(1, ad(4, 1, 2), 4'd10);
    send(ad(5, 2, 3), 4'd11);
    settle();
    // R8: nine lines in set 3, then the first is gone and the second is evicted by it
    phase = "R8";
    for (int t = 10; t < 19; t++) begin send(ad(t, 3, t % 16), 4'(t)); settle(); end
    send(ad(10, 3, 1), 4'd12); settle();
    cyc(1, ad(12, 3, 2), 4'd13); cyc(1, ad(11, 3, 2), 4'd14); settle();
    // R10: stray refill in idle installs nothing
    phase = "R10";
    spur = 1; spur_blk = ad(20, 0, 0) >> 6;
    cyc(0, '0, '0);
    cyc(1, ad(20, 0, 4), 4'd15); settle();
    // R9: mixed traffic
    phase = "R9";
    for (int i = 0; i < 600; i++) begin
      int r = int'($urandom % 100);
      cyc(r < 60, ad(int'($urandom % 6), int'($urandom % 4), int'($urandom % 16)), 4'($urandom));
    end
    settle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule